// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block supervises software with a 7-bit down-counter that a prescaler steps forward. Once software arms it, software must reload the counter on time. The reload must not be too late: if the counter falls from 0x40 to 0x3F, the block requests a system reset. The reload must not be too early either: a reload while the counter is still above a programmable window limit also requests a reset. An optional early-warning interrupt is raised one step before the late-reload reset, when the counter reaches 0x40. This gives software a last chance to log state or recover.

The counter runs all the time, armed or not. The prescaler divides the clock by a base (a power of two) times 1, 2, 4 or 8. A register write never restarts the prescaler, so a timeout can vary by up to one tick period. The block is controlled through a small register port with three registers: control, configuration and status. Its outputs are a single-cycle reset request and a level interrupt.

The control logic is a three-state machine:
- **IDLE**: not armed. The machine goes to ARMED on a control write with the arm bit set. It goes to FIRE if that write also clears counter bit 6.
- **ARMED**: supervising. The machine goes to FIRE on a late expiry, an early reload or a software reset write.
- **FIRE**: lasts exactly one cycle, with the reset request high. The machine always returns to IDLE.

Top module: `win_watchdog`

## Requirements
- R1: After reset the block is unarmed and reads count 0x7F, window 0x7F, divider select 0, warning enable 0 and status flag 0. The reset request and the interrupt are both low.
- R2: The counter decrements by one every BASE·2^sel clock cycles, where sel is the 2-bit divider select, whether the block is armed or not. The counter wraps from 0x00 to 0x7F. A control write does not restart the divider phase.
- R3: A control write with bit 7 set arms the block. A later control write with bit 7 clear leaves it armed. Only a reset pulse disarms it.
- R4: While the block is armed, a decrement from 0x40 raises the reset request in the cycle after that clock edge, together with a count of 0x3F. While the block is unarmed, no reset is ever requested on the way past 0x40.
- R5: While the block is armed, a control write made while the count is greater than the window raises the reset request, and the written count is not loaded.
- R6: While the block is armed, a control write with bit 6 set, made while the count is not above the window, loads bits 6:0 into the counter and requests no reset.
- R7: A control write with bit 6 clear, made while the block is armed or with bit 7 set, requests a reset (software reset). The written count is still loaded.
- R8: While the block is unarmed, a control write loads the counter even above the window and requests no reset.
- R9: When the warning enable is set and the counter decrements to 0x40, status bit 0 sets and the interrupt goes high. Both stay high until cleared, even across a reset pulse.
- R10: Writing status bit 0 as 0 clears the flag and lowers the interrupt. Writing it as 1 has no effect.
- R11: The reset request is high for exactly one cycle. From the following cycle on, the arm bit, window (0x7F), divider select (0) and warning enable (0) read back as their reset values.
- R12: The register address selects the register: 0 is control, 1 is configuration and 2 is status. Control holds the count in bits 6:0 and the arm bit in bit 7. Configuration holds the window in bits 6:0, the divider select in bits 8:7 and the warning enable in bit 9. Status holds the flag in bit 0. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that drives the prescaler |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select for reads and writes |
| bus_wdata | input | 10 | Write data |
| bus_rdata | output | 10 | Read data of the addressed register (combinational) |
| wdg_rst_req | output | 1 | Single-cycle system reset request |
| wdg_irq | output | 1 | Early-warning interrupt (level) |

## Verification
The write strobe is sampled at a clock edge. Register contents, the loaded count and the reset request all change at that same edge. The bench therefore reads them at the falling edge that follows. The reset request must fall again one cycle later, which the bench checks at the next falling edge.

A decrement lands on the prescaler edge. The bench first synchronises on an observed count change, so it knows the prescaler phase. It then predicts the exact cycle of each later change: BASE·2^sel cycles apart, and unaffected by a reload made in between. A warning flag set on the way to 0x40 is visible at the same falling edge at which the count first reads 0x40.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int CNT_W  = 7;
    localparam int DATA_W = 10;
    localparam int ADDR_W = 2;
    localparam int SEL_W  = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CFG  = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

    localparam logic [CNT_W-1:0] CNT_INIT  = 7'h7F;
    localparam logic [CNT_W-1:0] WIN_INIT  = 7'h7F;
    localparam logic [CNT_W-1:0] CNT_FLOOR = 7'h40;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRE  = 2'd2
    } wdg_state_e;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int BASE  = 4096,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int LOG_B = $clog2(BASE);
    localparam int DIV_W = LOG_B + (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;
    logic [DIV_W-1:0] one_v;

    assign one_v = {{(DIV_W-1){1'b0}}, 1'b1};
    assign mask  = (one_v << (LOG_B + int'(sel))) - one_v;
    assign tick  = ((div_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + one_v;
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (BASE > 1)) |=> !tick);
endmodule

// File: rtl/wdg_cfg.sv
module wdg_cfg
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic             stat_wr,
    input  logic             stat_bit,
    input  logic             restore,
    input  logic             warn,
    output logic [CNT_W-1:0] window,
    output logic [SEL_W-1:0] psel,
    output logic             ewi_en,
    output logic             flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            window <= WIN_INIT;
            psel   <= '0;
            ewi_en <= 1'b0;
        end else if (restore) begin
            window <= WIN_INIT;
            psel   <= '0;
            ewi_en <= 1'b0;
        end else if (cfg_wr) begin
            window <= cfg_data[CNT_W-1:0];
            psel   <= cfg_data[CNT_W+SEL_W-1:CNT_W];
            ewi_en <= cfg_data[CNT_W+SEL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  flag <= 1'b0;
        else if (warn && ewi_en)     flag <= 1'b1;
        else if (stat_wr && !stat_bit) flag <= 1'b0;
    end

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(stat_wr && !stat_bit));

    // R11
    defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (window == WIN_INIT && psel == '0 && !ewi_en));
endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctrl_wr,
    input  logic [7:0]       ctrl_data,
    input  logic [CNT_W-1:0] window,
    output logic [CNT_W-1:0] cnt_q,
    output logic             active,
    output logic             rst_req,
    output logic             trigger,
    output logic             warn
);
    wdg_state_e state_q, state_d;

    logic wr_ok, arm_after, trig_early, trig_soft, trig_late, load;

    assign wr_ok      = ctrl_wr && (state_q != ST_FIRE);
    assign arm_after  = (state_q == ST_ARMED) || ctrl_data[7];
    assign trig_early = wr_ok && (state_q == ST_ARMED) && (cnt_q > window);
    assign trig_soft  = wr_ok && !trig_early && arm_after && !ctrl_data[6];
    assign trig_late  = !wr_ok && (state_q == ST_ARMED) && tick && (cnt_q == CNT_FLOOR);
    assign trigger    = trig_early || trig_soft || trig_late;
    assign load       = wr_ok && !trig_early;
    assign warn       = tick && !load && (cnt_q == CNT_FLOOR + 7'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trigger)                     state_d = ST_FIRE;
                else if (wr_ok && ctrl_data[7])  state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (trigger) state_d = ST_FIRE;
            end
            ST_FIRE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        active  = 1'b0;
        rst_req = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ARMED: active  = 1'b1;
            ST_FIRE:  rst_req = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= CNT_INIT;
        else if (load) cnt_q <= ctrl_data[CNT_W-1:0];
        else if (tick) cnt_q <= cnt_q - 7'd1;
    end

    // R11
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R3
    arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> rst_req);

    // R4
    late_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick && !ctrl_wr && cnt_q == CNT_FLOOR) |=> rst_req);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ctrl_wr) |=> (cnt_q == $past(cnt_q) - 7'd1));
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import wdg_pkg::*;
#(
    parameter int PRESC_BASE = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [9:0]        bus_wdata,
    output logic [9:0]        bus_rdata,
    output logic              wdg_rst_req,
    output logic              wdg_irq
);
    logic             tick, active, trigger, warn, flag, ewi_en;
    logic [CNT_W-1:0] cnt, window;
    logic [SEL_W-1:0] psel;
    logic             ctrl_wr, cfg_wr, stat_wr;

    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
    assign cfg_wr  = bus_wr && (bus_addr == A_CFG) && !wdg_rst_req;
    assign stat_wr = bus_wr && (bus_addr == A_STAT);

    wdg_prescaler #(.BASE(PRESC_BASE), .SEL_W(SEL_W)) presc_i (
        .clk(clk), .rst_n(rst_n), .sel(psel), .tick(tick));

    wdg_core core_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_wr(ctrl_wr),
        .ctrl_data(bus_wdata[7:0]), .window(window), .cnt_q(cnt),
        .active(active), .rst_req(wdg_rst_req), .trigger(trigger), .warn(warn));

    wdg_cfg cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(bus_wdata),
        .stat_wr(stat_wr), .stat_bit(bus_wdata[0]), .restore(trigger),
        .warn(warn), .window(window), .psel(psel), .ewi_en(ewi_en), .flag(flag));

    assign wdg_irq = flag;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {2'b00, active, cnt};
            A_CFG:   bus_rdata = {ewi_en, psel, window};
            A_STAT:  bus_rdata = {9'd0, flag};
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/win_watchdog_tb_top.sv
module win_watchdog_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BASE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [9:0] bus_wdata = '0;
    logic [9:0] bus_rdata;
    logic       wdg_rst_req, wdg_irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int rst_cnt = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    win_watchdog #(.PRESC_BASE(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdg_rst_req(wdg_rst_req), .wdg_irq(wdg_irq));

    always @(negedge clk) if (rst_n && wdg_rst_req) rst_cnt++;

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [9:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [9:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_change(output int n);
        logic [9:0] a, b;
        rd(2'd0, a);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            rd(2'd0, b);
        end while (b[6:0] == a[6:0] && n < 1000);
    endtask

    initial begin
        logic [9:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R12 layout
        rd(2'd0, v); chk("R1 ctrl", v, 10'h07F);
        rd(2'd1, v); chk("R1 cfg", v, 10'h07F);
        rd(2'd2, v); chk("R1 status", v, 0);
        chk("R1 rst_req", wdg_rst_req, 0);
        chk("R1 irq", wdg_irq, 0);

        // R2 divider sweep, unarmed
        for (int p = 0; p < 4; p++) begin
            wr(2'd1, 10'((p << 7) | 10'h07F));
            wait_change(n); wait_change(n); wait_change(n);
            chk("R2 period", n, BASE << p);
        end

        // R2 phase kept across a control write
        wr(2'd1, 10'h07F);
        wait_change(n); wait_change(n);
        wr(2'd0, 10'h070);
        rd(2'd0, v); chk("R2 load", v, 10'h070);
        @(negedge clk); rd(2'd0, v); chk("R2 phase hold", v, 10'h070);
        @(negedge clk); rd(2'd0, v); chk("R2 phase step", v, 10'h06F);

        // R8 unarmed early write
        wr(2'd1, 10'h050);
        wr(2'd0, 10'h07F);
        chk("R8 no reset", wdg_rst_req, 0);
        rd(2'd0, v); chk("R8 reload", v, 10'h07F);

        // R3 arm, R6 reload with arm bit clear
        wr(2'd1, 10'h27F);
        wr(2'd0, 10'h0FF);
        rd(2'd0, v); chk("R3 armed", v, 10'h0FF);
        wr(2'd0, 10'h07E);
        chk("R6 no reset", wdg_rst_req, 0);
        rd(2'd0, v); chk("R3 stays armed", v, 10'h0FE);

        // R6 in-window reload
        wr(2'd1, 10'h260);
        n = 0;
        do begin @(negedge clk); rd(2'd0, v); n++; end while (v[6:0] > 7'h60 && n < 2000);
        wr(2'd0, 10'h0C8);
        chk("R6 no reset", wdg_rst_req, 0);
        rd(2'd0, v); chk("R6 loaded", v, 10'h0C8);
        chk("R4 none while unarmed or valid", rst_cnt, 0);

        // R9 warning, R4 late expiry, R11 pulse and defaults
        n = 0;
        do begin @(negedge clk); rd(2'd0, v); n++; end while (v[6:0] != 7'h40 && n < 2000);
        rd(2'd2, v); chk("R9 flag", v, 1);
        chk("R9 irq", wdg_irq, 1);
        n = 0;
        do begin @(negedge clk); rd(2'd0, v); n++; end while (v[6:0] == 7'h40 && n < 2000);
        chk("R4 rst_req", wdg_rst_req, 1);
        chk("R4 count", v[6:0], 7'h3F);
        @(negedge clk);
        chk("R11 pulse width", wdg_rst_req, 0);
        chk("R11 single pulse", rst_cnt, 1);
        rd(2'd1, v); chk("R11 cfg defaults", v, 10'h07F);
        rd(2'd0, v); chk("R11 disarmed", v[7], 0);
        rd(2'd2, v); chk("R9 flag held", v, 1);

        // R10 flag clearing
        wr(2'd2, 10'h001);
        rd(2'd2, v); chk("R10 write one", v, 1);
        wr(2'd2, 10'h000);
        rd(2'd2, v); chk("R10 cleared", v, 0);
        chk("R10 irq low", wdg_irq, 0);

        // R5 early reload while armed
        wr(2'd1, 10'h050);
        wr(2'd0, 10'h0FF);
        wr(2'd0, 10'h0F0);
        chk("R5 rst_req", wdg_rst_req, 1);
        rd(2'd0, v); chk("R5 not loaded", int'(v[6:0] >= 7'h7E), 1);
        @(negedge clk);
        rd(2'd1, v); chk("R11 cfg defaults", v, 10'h07F);

        // R7 software reset from unarmed and from armed
        wr(2'd0, 10'h0A5);
        chk("R7 unarmed soft", wdg_rst_req, 1);
        rd(2'd0, v); chk("R7 loaded", v, 10'h025);
        @(negedge clk);
        wr(2'd0, 10'h0FF);
        wr(2'd0, 10'h030);
        chk("R7 armed soft", wdg_rst_req, 1);
        rd(2'd0, v); chk("R7 loaded armed", v, 10'h030);
        @(negedge clk);

        // R12 configuration field layout
        wr(2'd1, 10'h3AA);
        rd(2'd1, v); chk("R12 cfg fields", v, 10'h3AA);
        rd(2'd3, v); chk("R12 unused addr", v, 0);

        finish_run();
    end
endmodule